// File: doc/BRIEF.md
# Voltage-ID Slew and Shutdown Sequencer

This block is the digital sequencer for one step-down regulator channel. It owns the reference code that feeds the channel's DAC. It moves that code toward a goal by a single step on each slew-clock tick. While the channel runs, the goal is the currently selected voltage code. A suspend select picks between a five-bit direct code and a small decoder that turns a two-bit suspend index into a code. When the channel is shut down or the supply is not yet valid, the goal is zero. There is no separate soft-start phase. The code starts from zero and follows the goal at once, and a goal that changes in the middle of a ramp is tracked from the code already reached.

Once the code has sat at zero for a fixed number of ticks while the channel is off, the block parks the gate drives. The low-side drive is held on and the high-side drive is held off. The same override applies at once whenever the supply flag drops, and whenever a fault latch is set. The fault latch also holds the linear-regulator enable low. Reset clears the latch, and so does any edge on the shutdown request.

Top module: `vslew_seq_top`

## Requirements
- R1: On a clock where `tick` is high, `dac_code` moves one step toward the goal (plus one if below, minus one if above, unchanged if equal). On a clock where `tick` is low, `dac_code` does not change.
- R2: While running, the goal comes from `susp_sel`. When it is 0, the goal is `vid_code`. When it is 1, the goal is SUSP_BASE + SUSP_STEP × `susp_idx`; with the defaults, indices 0 to 3 give codes 8, 12, 16 and 20.
- R3: The channel runs when `supply_ok` is 1 and `shdn_req` is 0. When it is not running, the goal is 0 and the code ramps down to 0.
- R4: If the goal changes during a ramp, stepping continues from the present code and does not restart from zero.
- R5: `settled` is high for exactly the one cycle after a tick edge on which the code, previously different from the goal, became equal to it.
- R6: While not running, each tick taken with the code already at 0 is counted. After PARK_TICKS such ticks (32 by default), `ls_force_on` and `hs_force_off` are both 1. They drop in the cycle after the channel starts running again, unless R7 or R8 still holds them.
- R7: While `supply_ok` is 0, `ls_force_on` and `hs_force_off` are 1 with no clock delay.
- R8: A 1 on `fault_in` at a clock edge sets `fault_latched`. While it is set, `ls_force_on` and `hs_force_off` are 1 and `lin_en` is 0.
- R9: A clock edge at which `shdn_req` differs from its value at the previous edge clears `fault_latched`, unless `fault_in` is 1 at that same edge, in which case setting wins.
- R10: `lin_en` equals `lin_req` whenever `fault_latched` is 0.
- R11: After reset, `dac_code` is 0, `settled` is 0, `fault_latched` is 0 and the park count is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset (power-on) |
| tick | input | 1 | One-cycle slew-clock tick enable |
| shdn_req | input | 1 | Shutdown request, 1 = shut down |
| supply_ok | input | 1 | Supply above lockout threshold |
| susp_sel | input | 1 | 0 = direct code, 1 = suspend decoder |
| vid_code | input | CODE_W | Direct target code |
| susp_idx | input | IDX_W | Suspend decoder index |
| fault_in | input | 1 | Fault event from protection comparators |
| lin_req | input | 1 | Linear regulator enable request |
| dac_code | output | CODE_W | Reference DAC code |
| settled | output | 1 | One-cycle pulse when code reaches goal |
| ls_force_on | output | 1 | Low-side drive forced on |
| hs_force_off | output | 1 | High-side drive forced off |
| lin_en | output | 1 | Linear regulator enable |
| fault_latched | output | 1 | Fault latch state |

## Verification
The hardest condition to reach from the ports is the park. It needs a shutdown ramp that has finished, followed by 32 further ticks at code zero with no intervening restart. The stimulus holds shutdown long enough to finish the ramp and then run the tick count, and it checks that the overrides stay clear before the count is complete. The goal change in the middle of a ramp is reached by switching the direct code after a counted number of ticks, so that the reversal point is known. A shutdown toggle is placed right after a fault to show that the latch is cleared by the toggle rather than by reset.

// File: rtl/vslew_pkg.sv
package vslew_pkg;

  typedef struct packed {
    logic ls_on;
    logic hs_off;
  } gate_ovr_t;

  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DOWN = 2'd2
  } step_dir_t;

endpackage

// File: rtl/vslew_goal_sel.sv
module vslew_goal_sel #(
  parameter int unsigned CODE_W    = 5,
  parameter int unsigned IDX_W     = 2,
  parameter int unsigned SUSP_BASE = 8,
  parameter int unsigned SUSP_STEP = 4
) (
  input  logic              run,
  input  logic              susp_sel,
  input  logic [CODE_W-1:0] vid_code,
  input  logic [IDX_W-1:0]  susp_idx,
  output logic [CODE_W-1:0] goal
);

  function automatic logic [CODE_W-1:0] susp_decode(input logic [IDX_W-1:0] idx);
    return CODE_W'(SUSP_BASE + SUSP_STEP * int'(idx));
  endfunction

  logic [CODE_W-1:0] picked;

  always_comb begin
    picked = susp_sel ? susp_decode(susp_idx) : vid_code;
    goal   = run ? picked : '0;
  end

endmodule

// File: rtl/vslew_stepper.sv
module vslew_stepper
  import vslew_pkg::*;
#(
  parameter int unsigned CODE_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [CODE_W-1:0] goal,
  output logic [CODE_W-1:0] code,
  output logic              settled
);

  function automatic step_dir_t pick_dir(input logic [CODE_W-1:0] cur,
                                         input logic [CODE_W-1:0] tgt);
    if (cur < tgt)      return STEP_UP;
    else if (cur > tgt) return STEP_DOWN;
    else                return STEP_HOLD;
  endfunction

  step_dir_t         dir;
  logic [CODE_W-1:0] code_nxt;
  logic              lands;

  always_comb begin
    dir = pick_dir(code, goal);
    unique case (dir)
      STEP_UP:   code_nxt = code + 1'b1;
      STEP_DOWN: code_nxt = code - 1'b1;
      default:   code_nxt = code;
    endcase
    lands = tick && (dir != STEP_HOLD) && (code_nxt == goal);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code    <= '0;
      settled <= 1'b0;
    end else begin
      settled <= lands;
      if (tick) code <= code_nxt;
    end
  end

endmodule

// File: rtl/vslew_park_guard.sv
module vslew_park_guard #(
  parameter int unsigned PARK_TICKS = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic run,
  input  logic code_zero,
  output logic parked
);

  localparam int unsigned CNT_W = $clog2(PARK_TICKS + 1);

  logic [CNT_W-1:0] cnt;

  assign parked = (cnt == CNT_W'(PARK_TICKS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           cnt <= '0;
    else if (run)                         cnt <= '0;
    else if (tick && code_zero && !parked) cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/vslew_fault_latch.sv
module vslew_fault_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic fault_in,
  input  logic shdn_req,
  output logic fault_q
);

  logic shdn_prev;
  logic shdn_edge;

  assign shdn_edge = (shdn_req != shdn_prev);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_q   <= 1'b0;
      shdn_prev <= 1'b0;
    end else begin
      shdn_prev <= shdn_req;
      if (fault_in)       fault_q <= 1'b1;
      else if (shdn_edge) fault_q <= 1'b0;
    end
  end

endmodule

// File: rtl/vslew_seq_top.sv
module vslew_seq_top
  import vslew_pkg::*;
#(
  parameter int unsigned CODE_W     = 5,
  parameter int unsigned IDX_W      = 2,
  parameter int unsigned SUSP_BASE  = 8,
  parameter int unsigned SUSP_STEP  = 4,
  parameter int unsigned PARK_TICKS = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              shdn_req,
  input  logic              supply_ok,
  input  logic              susp_sel,
  input  logic [CODE_W-1:0] vid_code,
  input  logic [IDX_W-1:0]  susp_idx,
  input  logic              fault_in,
  input  logic              lin_req,
  output logic [CODE_W-1:0] dac_code,
  output logic              settled,
  output logic              ls_force_on,
  output logic              hs_force_off,
  output logic              lin_en,
  output logic              fault_latched
);

  logic              run;
  logic [CODE_W-1:0] goal;
  logic              parked;
  gate_ovr_t         ovr;

  assign run = supply_ok && !shdn_req;

  vslew_goal_sel #(
    .CODE_W(CODE_W), .IDX_W(IDX_W),
    .SUSP_BASE(SUSP_BASE), .SUSP_STEP(SUSP_STEP)
  ) goal_i (
    .run(run), .susp_sel(susp_sel), .vid_code(vid_code),
    .susp_idx(susp_idx), .goal(goal)
  );

  vslew_stepper #(.CODE_W(CODE_W)) step_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .goal(goal),
    .code(dac_code), .settled(settled)
  );

  vslew_park_guard #(.PARK_TICKS(PARK_TICKS)) park_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .run(run),
    .code_zero(dac_code == '0), .parked(parked)
  );

  vslew_fault_latch fault_i (
    .clk(clk), .rst_n(rst_n), .fault_in(fault_in),
    .shdn_req(shdn_req), .fault_q(fault_latched)
  );

  always_comb begin
    ovr.ls_on  = !supply_ok || fault_latched || parked;
    ovr.hs_off = !supply_ok || fault_latched || parked;
  end

  assign ls_force_on  = ovr.ls_on;
  assign hs_force_off = ovr.hs_off;
  assign lin_en       = lin_req && !fault_latched;

endmodule

// File: rtl/vslew_seq_chk.sv
module vslew_seq_chk #(
  parameter int unsigned CODE_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic              shdn_req,
  input logic              supply_ok,
  input logic              fault_in,
  input logic [CODE_W-1:0] dac_code,
  input logic              settled,
  input logic              ls_force_on,
  input logic              hs_force_off,
  input logic              lin_en,
  input logic              fault_latched
);

  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> ((CODE_W'(dac_code - $past(dac_code)) <= 1) ||
              (CODE_W'($past(dac_code) - dac_code) == 1))); // R1

  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(dac_code)); // R1

  AST_OFF_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (shdn_req || !supply_ok) |=> (dac_code <= $past(dac_code))); // R3

  AST_SETTLE_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    settled |-> $past(tick)); // R5

  AST_PARK_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (ls_force_on && supply_ok && !fault_latched) |-> (dac_code == '0)); // R6

  AST_UVLO_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |-> (ls_force_on && hs_force_off)); // R7

  AST_FAULT_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
    fault_latched |-> (ls_force_on && hs_force_off && !lin_en)); // R8

  AST_FAULT_SET: assert property (@(posedge clk) disable iff (!rst_n)
    fault_in |=> fault_latched); // R8

  AST_TOGGLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    ((shdn_req != $past(shdn_req)) && !fault_in) |=> !fault_latched); // R9

endmodule

bind vslew_seq_top vslew_seq_chk #(.CODE_W(CODE_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .tick(tick), .shdn_req(shdn_req),
  .supply_ok(supply_ok), .fault_in(fault_in), .dac_code(dac_code),
  .settled(settled), .ls_force_on(ls_force_on), .hs_force_off(hs_force_off),
  .lin_en(lin_en), .fault_latched(fault_latched)
);

// File: tb/vslew_seq_top_tb_top.sv
`timescale 1ns/1ps
module vslew_seq_top_tb_top;

  localparam int CW   = 5;
  localparam int PARK = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tick = 1'b0, shdn_req = 1'b1, supply_ok = 1'b0, susp_sel = 1'b0;
  logic [CW-1:0] vid_code = '0;
  logic [1:0]    susp_idx = '0;
  logic          fault_in = 1'b0, lin_req = 1'b0;
  logic [CW-1:0] dac_code;
  logic          settled, ls_force_on, hs_force_off, lin_en, fault_latched;

  int checks = 0;
  int errors = 0;
  int tick_div = 2;
  int cyc = 0;
  int settle_seen = 0;
  bit done = 0;

  // behavioural reference state
  int m_code = 0, m_cnt = 0;
  bit m_fault = 0, m_settled = 0, m_prev = 0;

  always #5 clk = ~clk;

  vslew_seq_top dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .shdn_req(shdn_req),
    .supply_ok(supply_ok), .susp_sel(susp_sel), .vid_code(vid_code),
    .susp_idx(susp_idx), .fault_in(fault_in), .lin_req(lin_req),
    .dac_code(dac_code), .settled(settled), .ls_force_on(ls_force_on),
    .hs_force_off(hs_force_off), .lin_en(lin_en), .fault_latched(fault_latched)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int target_now();
    if (!(supply_ok && !shdn_req)) return 0;
    if (susp_sel) return 8 + 4 * int'(susp_idx);
    return int'(vid_code);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_code = 0; m_cnt = 0; m_fault = 0; m_settled = 0; m_prev = 0;
    end else begin
      int tgt, nxt;
      bit running;
      tgt = target_now();
      running = supply_ok && !shdn_req;
      nxt = m_code;
      if (tick) nxt = (m_code < tgt) ? m_code + 1 : (m_code > tgt) ? m_code - 1 : m_code;
      m_settled = tick && (m_code != tgt) && (nxt == tgt);
      if (running) m_cnt = 0;
      else if (tick && m_code == 0 && m_cnt < PARK) m_cnt++;
      if (fault_in) m_fault = 1;
      else if (shdn_req != m_prev) m_fault = 0;
      m_prev = shdn_req;
      m_code = nxt;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit exp_ovr;
      exp_ovr = !supply_ok || m_fault || (m_cnt == PARK);
      chk("R1 code", int'(dac_code), m_code);
      chk("R5 settled", int'(settled), int'(m_settled));
      chk("R6/R7/R8 ls_force_on", int'(ls_force_on), int'(exp_ovr));
      chk("R6/R7/R8 hs_force_off", int'(hs_force_off), int'(exp_ovr));
      chk("R8 fault_latched", int'(fault_latched), int'(m_fault));
      chk("R10 lin_en", int'(lin_en), int'(lin_req && !m_fault));
      if (settled) settle_seen++;
    end
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #2;
      cyc++;
      tick = (cyc % tick_div) == 0;
    end
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    lin_req = 1'b1;
    step(3);
    rst_n = 1'b1;
    step(1);
    @(negedge clk); #1;
    chk("R11 reset code", int'(dac_code), 0);
    chk("R11 reset fault", int'(fault_latched), 0);
    chk("R11 reset settled", int'(settled), 0);
    chk("R7 uvlo override", int'(ls_force_on), 1);

    // power up: ramp from zero to direct code 10
    supply_ok = 1'b1; shdn_req = 1'b0; vid_code = 5'd10;
    settle_seen = 0;
    step(30);
    chk("R1 ramp reached 10", int'(dac_code), 10);
    chk("R5 one settle pulse", settle_seen, 1);

    // R4: reverse mid-ramp
    vid_code = 5'd4;
    step(6);
    chk("R4 partway down", int'(dac_code), 7);
    vid_code = 5'd15;
    step(2);
    chk("R4 resumes from 7", int'(dac_code), 8);
    step(20);
    chk("R4 reached 15", int'(dac_code), 15);

    // R2: suspend decoder
    susp_sel = 1'b1; susp_idx = 2'd3;
    step(16);
    chk("R2 suspend idx3", int'(dac_code), 20);
    susp_idx = 2'd0;
    tick_div = 1;
    step(16);
    chk("R2 suspend idx0", int'(dac_code), 8);

    // R8 fault then R9 toggle clear
    fault_in = 1'b1; step(1); fault_in = 1'b0;
    step(3);
    chk("R8 fault held", int'(fault_latched), 1);
    chk("R8 lin off", int'(lin_en), 0);
    tick_div = 2;
    shdn_req = 1'b1;
    step(2);
    chk("R9 toggle clears", int'(fault_latched), 0);

    // R3 shutdown ramp then R6 park
    step(20);
    chk("R3 code at zero", int'(dac_code), 0);
    chk("R6 not yet parked", int'(ls_force_on), 0);
    step(70);
    chk("R6 parked ls", int'(ls_force_on), 1);
    chk("R6 parked hs", int'(hs_force_off), 1);
    shdn_req = 1'b0;
    step(1);
    chk("R6 unpark", int'(ls_force_on), 0);
    step(20);
    chk("R3 restart ramp", int'(dac_code), 8);

    // R9 set wins over toggle in the same cycle
    fault_in = 1'b1; shdn_req = 1'b1; step(1); fault_in = 1'b0;
    step(1);
    chk("R9 set beats toggle", int'(fault_latched), 1);
    shdn_req = 1'b0; step(2);
    chk("R9 second toggle clears", int'(fault_latched), 0);

    // R7 supply drop
    step(20);
    supply_ok = 1'b0;
    #1;
    chk("R7 immediate ls", int'(ls_force_on), 1);
    chk("R7 immediate hs", int'(hs_force_off), 1);
    step(30);
    chk("R3 uvlo ramp to zero", int'(dac_code), 0);
    supply_ok = 1'b1; vid_code = 5'd3; susp_sel = 1'b0; tick_div = 1;
    step(10);
    chk("R2 direct code 3", int'(dac_code), 3);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule